// File: doc/BRIEF.md
# Register-Indirect Load/Store Unit

This block carries out the memory-format instructions of a small 16-bit processor. It owns a private data memory of 256 words of 16 bits. For each request it decodes the instruction word, publishes the two register indices it needs on a register-file read port, and takes back the data register (rx) and the address register (ry) in the same cycle. A load writes the addressed word into rx. A store writes rx into the addressed word.

Results leave on a register write port: a write enable, a write index and the write data. A single-cycle done pulse marks each completed operation. The memory read is synchronous, so every response appears exactly one cycle after its request, and a new request can be accepted every cycle. Words of any other instruction format pass through without effect. A memory-format word whose reserved bits are not all zero is discarded and flagged.

Top module: `ldst_unit`

## Requirements
- R1: A request whose bits 1:0 are not binary 11 produces no done, no register write and no illegal flag in the next cycle, and it leaves the data memory unchanged.
- R2: A load (bits 1:0 = 11, bit 2 = 0, bits 9:3 = 0) raises wr_en_o and done_o in the cycle after the request. In that cycle wr_idx_o equals instruction bits 15:13, and wr_data_o equals the memory word at the address held in ry.
- R3: A store (bits 1:0 = 11, bit 2 = 1, bits 9:3 = 0) writes the rx data into the memory word addressed by ry. It pulses done_o in the next cycle with wr_en_o low.
- R4: Only bits 7:0 of the ry data form the address. Bits 15:8 have no effect on which word is accessed.
- R5: A memory-format word with any of bits 9:3 set is a no-op. The memory is unchanged, there is no write and no done, and illegal_o is high for the one cycle after the request.
- R6: rf_rx_idx_o always equals instruction bits 15:13, and rf_ry_idx_o always equals bits 12:10, with no delay.
- R7: Requests may arrive in consecutive cycles. A load issued the cycle after a store to the same address returns the stored data.
- R8: While reset is asserted and after it is released, done_o, wr_en_o, illegal_o, wr_idx_o and wr_data_o are zero until a request arrives.
- R9: done_o, wr_en_o and illegal_o are one-cycle pulses. A cycle with no request is followed by a cycle with all three low, and wr_en_o never rises without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Instruction valid this cycle |
| instr_i | input | 16 | Instruction word |
| rf_rx_idx_o | output | 3 | Register-file read index for rx |
| rf_ry_idx_o | output | 3 | Register-file read index for ry |
| rf_rx_data_i | input | 16 | Contents of rx (store data) |
| rf_ry_data_i | input | 16 | Contents of ry (address) |
| wr_en_o | output | 1 | Register write enable (loads only) |
| wr_idx_o | output | 3 | Register write index |
| wr_data_o | output | 16 | Register write data |
| done_o | output | 1 | Operation completed |
| illegal_o | output | 1 | Memory-format word with reserved bits set |

## Verification
The hardest situation to reach from the ports is a store followed in the very next cycle by a load of the same word, because the synchronous read must see the write of the previous edge. Random traffic seldom produces this, so the bench issues directed store-then-load pairs. Random addresses also draw from a narrow window so that such collisions recur. The whole memory is first filled by stores so that every later load has a known expected value. Because of this, discarded requests (foreign formats, reserved bits set) can be shown to leave memory untouched by reading the target word back.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int INSTR_W = 16;
  localparam int RIDX_W  = 3;
  // field positions of the memory instruction format
  localparam int RX_LSB  = 13;
  localparam int RY_LSB  = 10;
  localparam int RSV_MSB = 9;
  localparam int RSV_LSB = 3;
  localparam int LS_BIT  = 2;
  localparam logic [1:0] FMT_MEM = 2'b11;

  typedef logic [RIDX_W-1:0] ridx_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_BAD   = 2'd3
  } mem_op_e;

  typedef struct packed {
    mem_op_e op;
    ridx_t   rx;
    ridx_t   ry;
  } mem_dec_t;

  function automatic ridx_t field_rx(input logic [INSTR_W-1:0] w);
    return w[RX_LSB +: RIDX_W];
  endfunction

  function automatic ridx_t field_ry(input logic [INSTR_W-1:0] w);
    return w[RY_LSB +: RIDX_W];
  endfunction
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic               req_i,
  input  logic [INSTR_W-1:0] instr_i,
  output mem_dec_t           dec_o
);
  logic is_mem;
  logic rsv_clean;

  assign is_mem    = req_i && (instr_i[1:0] == FMT_MEM);
  assign rsv_clean = (instr_i[RSV_MSB:RSV_LSB] == '0);

  always_comb begin
    dec_o.rx = field_rx(instr_i);
    dec_o.ry = field_ry(instr_i);
    if (!is_mem)           dec_o.op = OP_NONE;
    else if (!rsv_clean)   dec_o.op = OP_BAD;
    else if (instr_i[LS_BIT]) dec_o.op = OP_STORE;
    else                   dec_o.op = OP_LOAD;
  end
endmodule

// File: rtl/ldst_dmem.sv
module ldst_dmem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/ldst_resp.sv
module ldst_resp
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mem_op_e           op_i,
  input  ridx_t             rx_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              wr_en_o,
  output ridx_t             wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              illegal_o
);
  logic  load_q;
  ridx_t idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q    <= 1'b0;
      idx_q     <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      load_q    <= (op_i == OP_LOAD);
      done_o    <= (op_i == OP_LOAD) || (op_i == OP_STORE);
      illegal_o <= (op_i == OP_BAD);
      if (op_i == OP_LOAD) idx_q <= rx_i;
    end
  end

  assign wr_en_o   = load_q;
  assign wr_idx_o  = load_q ? idx_q : '0;
  assign wr_data_o = load_q ? rdata_i : '0;
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [15:0]       instr_i,
  output logic [2:0]        rf_rx_idx_o,
  output logic [2:0]        rf_ry_idx_o,
  input  logic [DATA_W-1:0] rf_rx_data_i,
  input  logic [DATA_W-1:0] rf_ry_data_i,
  output logic              wr_en_o,
  output logic [2:0]        wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              illegal_o
);
  mem_dec_t          dec;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-ADDR_W-1:0] ry_hi_unused;

  ldst_decode u_dec (
    .req_i   (req_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  assign rf_rx_idx_o  = dec.rx;
  assign rf_ry_idx_o  = dec.ry;
  assign addr         = rf_ry_data_i[ADDR_W-1:0];
  assign ry_hi_unused = rf_ry_data_i[DATA_W-1:ADDR_W];

  ldst_dmem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dec.op == OP_STORE),
    .re_i    (dec.op == OP_LOAD),
    .addr_i  (addr),
    .wdata_i (rf_rx_data_i),
    .rdata_o (rdata)
  );

  ldst_resp #(.DATA_W(DATA_W)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (dec.op),
    .rx_i      (dec.rx),
    .rdata_i   (rdata),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .wr_data_o (wr_data_o),
    .done_o    (done_o),
    .illegal_o (illegal_o)
  );
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [15:0] instr_i,
  input logic        wr_en_o,
  input logic [2:0]  wr_idx_o,
  input logic        done_o,
  input logic        illegal_o
);
  logic fmt_mem, rsv_zero;
  assign fmt_mem  = req_i && (instr_i[1:0] == 2'b11);
  assign rsv_zero = (instr_i[9:3] == 7'd0);

  a_r1_foreign_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && instr_i[1:0] != 2'b11) |=> (!done_o && !wr_en_o && !illegal_o));

  a_r2_load_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_mem && rsv_zero && !instr_i[2]) |=>
      (wr_en_o && done_o && wr_idx_o == $past(instr_i[15:13])));

  a_r3_store_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_mem && rsv_zero && instr_i[2]) |=> (done_o && !wr_en_o && !illegal_o));

  a_r5_reserved_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_mem && !rsv_zero) |=> (illegal_o && !done_o && !wr_en_o));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!done_o && !wr_en_o && !illegal_o));

  a_r9_write_has_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);
endmodule

bind ldst_unit ldst_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .instr_i   (instr_i),
  .wr_en_o   (wr_en_o),
  .wr_idx_o  (wr_idx_o),
  .done_o    (done_o),
  .illegal_o (illegal_o)
);

// File: tb/ldst_unit_test.sv
module ldst_unit_test;
  logic        clk_i = 0, rst_ni = 0, req_i = 0;
  logic [15:0] instr_i = '0, rf_rx_data_i = '0, rf_ry_data_i = '0;
  logic [2:0]  rf_rx_idx_o, rf_ry_idx_o, wr_idx_o;
  logic [15:0] wr_data_o;
  logic        wr_en_o, done_o, illegal_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] mdl [256];
  bit          exp_done = 0, exp_wr = 0, exp_ill = 0;
  logic [2:0]  exp_idx = '0;
  logic [15:0] exp_data = '0;
  string       exp_tag = "R8";

  always #5 clk_i = ~clk_i;

  ldst_unit uut (.*);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [2:0] rx, input logic [2:0] ry,
                                     input bit st, input logic [6:0] rsv);
    return {rx, ry, rsv, st, 2'b11};
  endfunction

  task automatic cycle(input bit req, input logic [15:0] ins,
                       input logic [15:0] rxd, input logic [15:0] ryd);
    @(negedge clk_i);
    chk(exp_tag, "done", done_o, exp_done);
    chk(exp_tag, "wr_en", wr_en_o, exp_wr);
    chk(exp_tag, "illegal", illegal_o, exp_ill);
    if (exp_wr) begin
      chk(exp_tag, "wr_idx", wr_idx_o, exp_idx);
      chk(exp_tag, "wr_data", wr_data_o, exp_data);
    end
    exp_done = 0; exp_wr = 0; exp_ill = 0;
    exp_tag = req ? "R1" : "R9";
    if (req && ins[1:0] == 2'b11) begin
      if (ins[9:3] != 0) begin
        exp_ill = 1; exp_tag = "R5";
      end else if (ins[2]) begin
        exp_done = 1; exp_tag = "R3";
        mdl[ryd[7:0]] = rxd;
      end else begin
        exp_done = 1; exp_wr = 1; exp_tag = "R2";
        exp_idx = ins[15:13]; exp_data = mdl[ryd[7:0]];
      end
    end
    req_i = req; instr_i = ins; rf_rx_data_i = rxd; rf_ry_data_i = ryd;
    #1;
    chk("R6", "rx idx", rf_rx_idx_o, ins[15:13]);
    chk("R6", "ry idx", rf_ry_idx_o, ins[12:10]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    chk("R8", "done", done_o, 0);
    chk("R8", "wr_en", wr_en_o, 0);
    chk("R8", "illegal", illegal_o, 0);
    chk("R8", "wr_data", wr_data_o, 0);
    rst_ni = 1;
    cycle(0, 16'h0, 16'h0, 16'h0);  // R8 after release
    // fill memory so all loads are predictable (R3)
    for (int a = 0; a < 256; a++)
      cycle(1, mk(3'($urandom), 3'($urandom), 1, 0), 16'($urandom),
            {8'($urandom), 8'(a)});
    // R4: upper ry bits ignored
    cycle(1, mk(3'd1, 3'd2, 1, 0), 16'hBEEF, 16'hAB12);
    cycle(1, mk(3'd4, 3'd2, 0, 0), 16'h0, 16'h0012);
    cycle(1, mk(3'd7, 3'd3, 0, 0), 16'h0, 16'hFF12);
    // R7: store then load same word next cycle, then load-load
    cycle(1, mk(3'd0, 3'd5, 1, 0), 16'h1357, 16'h0040);
    cycle(1, mk(3'd6, 3'd5, 0, 0), 16'h0, 16'h0040);
    cycle(1, mk(3'd2, 3'd5, 0, 0), 16'h0, 16'h0012);
    // R5: reserved bits set, memory must stay intact
    cycle(1, mk(3'd1, 3'd1, 1, 7'h01), 16'hDEAD, 16'h0005);
    cycle(1, mk(3'd1, 3'd1, 1, 7'h40), 16'hDEAD, 16'h0005);
    cycle(1, mk(3'd3, 3'd1, 0, 7'h7F), 16'h0, 16'h0005);
    cycle(1, mk(3'd3, 3'd1, 0, 0), 16'h0, 16'h0005);
    // R1: foreign formats with store-like bits
    cycle(1, 16'hFFF6, 16'hCAFE, 16'h0009);
    cycle(1, 16'h0005, 16'hCAFE, 16'h0009);
    cycle(1, mk(3'd5, 3'd0, 0, 0), 16'h0, 16'h0009);
    // R9: idle cycles
    cycle(0, 16'h0, 16'h0, 16'h0);
    cycle(0, mk(3'd1, 3'd1, 1, 0), 16'h7777, 16'h0009);
    cycle(1, mk(3'd5, 3'd0, 0, 0), 16'h0, 16'h0009);
    // constrained random; narrow address window for collisions (R7)
    for (int i = 0; i < 4000; i++) begin
      automatic int sel = $urandom_range(0, 99);
      automatic logic [15:0] ins;
      automatic logic [15:0] ry = {8'($urandom), 4'h0, 4'($urandom)};
      if (sel < 40)      ins = mk(3'($urandom), 3'($urandom), 0, 0);
      else if (sel < 75) ins = mk(3'($urandom), 3'($urandom), 1, 0);
      else if (sel < 85) ins = mk(3'($urandom), 3'($urandom), 1'($urandom),
                                  7'($urandom_range(1, 127)));
      else               ins = {14'($urandom), 2'($urandom_range(0, 2))};
      cycle(sel < 95, ins, 16'($urandom), ry);
    end
    cycle(0, 16'h0, 16'h0, 16'h0);
    cycle(0, 16'h0, 16'h0, 16'h0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule